// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator

This block raises an interrupt at a regular rate derived from a slow timebase. A strobe input, `base_tick`, pulses once per base period: 128 times a second in the default build, or 32768 times a second when `BASE_LOG2` is set to 15. A down counter runs on those strobes. Each time the counter is seen at zero, it reloads and a sticky pending flag is set. Software clears that flag by writing a one to it. The interrupt period is therefore the reload value plus one base ticks.

Software configures the block in one of three ways:
- A full register write sets both the enable bit and the reload field.
- A count-only write replaces the reload field and leaves the enable bit as it is.
- A rate write takes the base-2 logarithm of the wanted interrupt frequency and computes the reload itself, as base rate divided by wanted rate, minus one. Only power-of-two rates can be expressed this way. A rate above the base rate is refused.

While the enable bit is clear, the counter holds its value and no interrupt is produced. Setting the enable bit again starts a fresh period.

Top module: `tick_irq_gen`

## Requirements
- R1: After reset, `irq`, `tick_evt`, `cur_count` and `cfg_rdata` are all zero.
- R2: A full write (`reg_wr`) stores bit `BASE_LOG2` of `reg_wdata` as the enable bit and bits `BASE_LOG2-1:0` as the reload field. `cfg_rdata` returns them at the same positions.
- R3: A full write that sets the enable bit while it is clear loads `cur_count` with the written reload. A base tick in that same cycle is not consumed.
- R4: While enabled, each base tick decrements `cur_count`. A base tick that finds `cur_count` at zero fires and reloads it from the reload field. The first interrupt therefore comes on base tick reload+1 after enabling, and every later one reload+1 ticks after the previous one.
- R5: A rate write with `rate_sel` = k, where k is at most `BASE_LOG2`, sets the reload to 2^(BASE_LOG2-k)-1 and keeps the enable bit. A rate write with k greater than `BASE_LOG2` changes nothing.
- R6: A count-only write (`cnt_wr`) replaces the reload field and keeps the enable bit. It does not disturb a running count: the new value first applies at the next reload.
- R7: While the enable bit is clear, base ticks leave `cur_count` unchanged and set no pending flag, and an existing pending flag keeps its value.
- R8: A fire sets `irq`, which then stays high until a `pend_clr` pulse. If a fire and a clear happen in the same cycle, the fire wins.
- R9: `tick_evt` is high for exactly one cycle per fire, in the same cycle in which `irq` is set by it.
- R10: A full write with the enable bit set, made while the block is already enabled, does not reload `cur_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One-cycle timebase strobe, one per base period |
| reg_wr | input | 1 | Full register write strobe |
| reg_wdata | input | BASE_LOG2+1 | Enable bit (MSB) and reload field |
| cnt_wr | input | 1 | Reload-only write strobe |
| cnt_wdata | input | BASE_LOG2 | New reload value |
| rate_wr | input | 1 | Rate write strobe |
| rate_sel | input | $clog2(BASE_LOG2+1)+1 | Base-2 logarithm of the wanted interrupt rate |
| pend_clr | input | 1 | Write-one-to-clear pulse for the pending flag |
| cfg_rdata | output | BASE_LOG2+1 | Readback of the enable bit and the reload field |
| cur_count | output | BASE_LOG2 | Present counter value |
| irq | output | 1 | Pending interrupt level |
| tick_evt | output | 1 | One-cycle pulse per fire |

## Verification
A wrong counter value shows up at `cur_count` on the next clock, and as a period that differs from reload+1 by the time the next interrupt arrives. A wrong reload computed from a rate write shows up on `cfg_rdata` one cycle after the write. A lost enable bit shows up there at the same moment and, within one base tick, as a frozen counter. A pending flag that is dropped or set wrongly shows up on `irq` in the cycle after the offending clear, or after the offending base tick while disabled. The bench sweeps every rate code, and a range of direct reloads up to the maximum, measuring two full periods for each.

// File: rtl/tick_pkg.sv
package tick_pkg;

  // Reload that yields 2**rate_log2 interrupts per second on a 2**base_log2 base.
  function automatic int unsigned rate_reload(input int unsigned base_log2,
                                              input int unsigned rate_log2);
    return (32'd1 << (base_log2 - rate_log2)) - 32'd1;
  endfunction

  // A rate is usable only when it does not exceed the base rate.
  function automatic bit rate_ok(input int unsigned base_log2,
                                 input int unsigned rate_log2);
    return rate_log2 <= base_log2;
  endfunction

endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs #(
  parameter int BASE_LOG2 = 7,
  parameter int CNT_W     = BASE_LOG2,
  parameter int RATE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CNT_W:0]    reg_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              en_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              arm,
  output logic [CNT_W-1:0]  arm_value
);
  import tick_pkg::*;

  logic             rate_valid;
  logic [CNT_W-1:0] rate_value;

  assign rate_valid = rate_ok(BASE_LOG2, 32'(rate_sel));
  assign rate_value = CNT_W'(rate_reload(BASE_LOG2, 32'(rate_sel)));

  // Start of a fresh period: enable goes from clear to set.
  assign arm       = reg_wr && reg_wdata[CNT_W] && !en_q;
  assign arm_value = reg_wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      reload_q <= '0;
    end else if (reg_wr) begin
      en_q     <= reg_wdata[CNT_W];
      reload_q <= reg_wdata[CNT_W-1:0];
    end else if (cnt_wr) begin
      reload_q <= cnt_wdata;
    end else if (rate_wr && rate_valid) begin
      reload_q <= rate_value;
    end
  end

endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             arm,
  input  logic [CNT_W-1:0] arm_value,
  input  logic [CNT_W-1:0] reload,
  input  logic             base_tick,
  output logic [CNT_W-1:0] count_q,
  output logic             fire
);
  logic at_zero;
  logic step;

  assign at_zero = (count_q == '0);
  assign step    = en && base_tick && !arm;
  assign fire    = step && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (arm) begin
      count_q <= arm_value;
    end else if (step) begin
      count_q <= at_zero ? reload : count_q - 1'b1;
    end
  end

endmodule

// File: rtl/tick_pend_flag.sv
module tick_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clr,
  output logic pend_q,
  output logic evt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= fire;
      if (fire)     pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen #(
  parameter int BASE_LOG2 = 7,
  localparam int CNT_W    = BASE_LOG2,
  localparam int RATE_W   = $clog2(BASE_LOG2 + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              reg_wr,
  input  logic [CNT_W:0]    reg_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pend_clr,
  output logic [CNT_W:0]    cfg_rdata,
  output logic [CNT_W-1:0]  cur_count,
  output logic              irq,
  output logic              tick_evt
);
  logic             en_w;
  logic [CNT_W-1:0] reload_w;
  logic             arm_w;
  logic [CNT_W-1:0] arm_val_w;
  logic             fire_w;

  tick_cfg_regs #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W), .RATE_W(RATE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .rate_wr(rate_wr), .rate_sel(rate_sel),
    .en_q(en_w), .reload_q(reload_w),
    .arm(arm_w), .arm_value(arm_val_w)
  );

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .en(en_w), .arm(arm_w), .arm_value(arm_val_w),
    .reload(reload_w), .base_tick(base_tick),
    .count_q(cur_count), .fire(fire_w)
  );

  tick_pend_flag u_pend (
    .clk(clk), .rst_n(rst_n),
    .fire(fire_w), .clr(pend_clr),
    .pend_q(irq), .evt_q(tick_evt)
  );

  assign cfg_rdata = {en_w, reload_w};

endmodule

// File: rtl/tick_irq_chk.sv
module tick_irq_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             base_tick,
  input logic             reg_wr,
  input logic [CNT_W:0]   reg_wdata,
  input logic             pend_clr,
  input logic [CNT_W:0]   cfg_rdata,
  input logic [CNT_W-1:0] cur_count,
  input logic             irq,
  input logic             tick_evt,
  input logic             fire,
  input logic             arm,
  input logic [CNT_W-1:0] reload
);
  a_r4_reload_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cur_count == $past(reload));

  a_r4_fire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> cur_count == '0);

  a_r3_arm_loads: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> cur_count == $past(reg_wdata[CNT_W-1:0]));

  a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[CNT_W] && !arm) |=> $stable(cur_count));

  a_r8_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !pend_clr) |=> irq);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !fire) |=> !irq);

  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq);

  a_r9_evt_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |-> irq);

  a_r10_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[CNT_W] && reg_wr && !base_tick) |=> $stable(cur_count));
endmodule

bind tick_irq_gen tick_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .pend_clr(pend_clr),
  .cfg_rdata(cfg_rdata), .cur_count(cur_count), .irq(irq),
  .tick_evt(tick_evt), .fire(fire_w), .arm(arm_w), .reload(reload_w)
);

// File: tb/sim_tick_irq_gen.sv
module sim_tick_irq_gen;
  localparam int BL = 7;
  localparam int CW = BL;
  localparam int RW = $clog2(BL + 1) + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          base_tick = 1'b0;
  logic          reg_wr = 1'b0;
  logic [CW:0]   reg_wdata = '0;
  logic          cnt_wr = 1'b0;
  logic [CW-1:0] cnt_wdata = '0;
  logic          rate_wr = 1'b0;
  logic [RW-1:0] rate_sel = '0;
  logic          pend_clr = 1'b0;
  logic [CW:0]   cfg_rdata;
  logic [CW-1:0] cur_count;
  logic          irq;
  logic          tick_evt;

  tick_irq_gen #(.BASE_LOG2(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .rate_wr(rate_wr), .rate_sel(rate_sel),
    .pend_clr(pend_clr), .cfg_rdata(cfg_rdata),
    .cur_count(cur_count), .irq(irq), .tick_evt(tick_evt)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  localparam int ENB = 1 << CW;

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr_full(input bit en, input int val);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = {en, CW'(val)};
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wr_cnt(input int val);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = CW'(val);
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic wr_rate(input int k);
    @(negedge clk); rate_wr = 1'b1; rate_sel = RW'(k);
    @(negedge clk); rate_wr = 1'b0;
  endtask

  task automatic clr_pend();
    @(negedge clk); pend_clr = 1'b1;
    @(negedge clk); pend_clr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); base_tick = 1'b1;
    @(negedge clk); base_tick = 1'b0;
  endtask

  // Number of the base tick on which irq first appears (0 if never).
  task automatic measure(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      tick();
      if (irq) begin n = i; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", int'(irq), 0);
    chk("R1 evt", int'(tick_evt), 0);
    chk("R1 count", int'(cur_count), 0);
    chk("R1 rdata", int'(cfg_rdata), 0);

    wr_full(1'b0, 8'h55);
    chk("R2 rdata off", int'(cfg_rdata), 'h55);
    wr_full(1'b1, 8'h23);
    chk("R2 rdata on", int'(cfg_rdata), ENB | 'h23);
    wr_full(1'b0, 0);
    clr_pend();

    // Direct reload sweep: two periods each
    for (int r = 0; r <= 20; r++) begin
      int rv;
      rv = (r == 20) ? (ENB - 1) : r;
      wr_full(1'b1, rv);
      chk("R3 arm count", int'(cur_count), rv);
      measure(rv + 3, n);
      chk("R4 first period", n, rv + 1);
      chk("R9 evt at fire", int'(tick_evt), 1);
      clr_pend();
      chk("R8 cleared", int'(irq), 0);
      measure(rv + 3, n);
      chk("R4 second period", n, rv + 1);
      wr_full(1'b0, 0);
      clr_pend();
    end

    // Rate sweep over every valid code
    for (int k = 0; k <= BL; k++) begin
      int ev;
      ev = (1 << (BL - k)) - 1;
      wr_full(1'b0, 0);
      clr_pend();
      wr_rate(k);
      chk("R5 rate reload", int'(cfg_rdata), ev);
      wr_full(1'b1, ev);
      measure(ev + 3, n);
      chk("R5 rate period", n, 1 << (BL - k));
      clr_pend();
      measure(ev + 3, n);
      chk("R4 rate period 2", n, 1 << (BL - k));
    end
    wr_full(1'b0, 0);
    clr_pend();

    // Refused rate codes
    wr_full(1'b0, 17);
    wr_rate(BL + 2);
    chk("R5 invalid ignored", int'(cfg_rdata), 17);
    wr_rate((1 << RW) - 1);
    chk("R5 invalid max ignored", int'(cfg_rdata), 17);
    wr_full(1'b1, 17);
    wr_rate(3);
    chk("R5 enable kept", int'(cfg_rdata), ENB | ((1 << (BL - 3)) - 1));
    wr_full(1'b0, 0);
    clr_pend();

    // Count-only write while running
    wr_full(1'b1, 9);
    repeat (3) tick();
    chk("R6 before", int'(cur_count), 6);
    wr_cnt(2);
    chk("R6 count undisturbed", int'(cur_count), 6);
    chk("R6 enable kept", int'(cfg_rdata), ENB | 2);
    measure(12, n);
    chk("R6 old period finishes", n, 7);
    clr_pend();
    measure(6, n);
    chk("R6 new period", n, 3);
    wr_full(1'b0, 0);
    clr_pend();

    // Re-write with enable while enabled
    wr_full(1'b1, 9);
    repeat (3) tick();
    wr_full(1'b1, 4);
    chk("R10 no reload", int'(cur_count), 6);
    chk("R10 rdata", int'(cfg_rdata), ENB | 4);
    measure(12, n);
    chk("R10 period ends", n, 7);
    wr_full(1'b0, 0);
    clr_pend();

    // Tick in the arming cycle is not consumed
    @(negedge clk); reg_wr = 1'b1; reg_wdata = {1'b1, CW'(5)}; base_tick = 1'b1;
    @(negedge clk); reg_wr = 1'b0; base_tick = 1'b0;
    chk("R3 tick with arm", int'(cur_count), 5);
    wr_full(1'b0, 0);

    // Disabled hold
    wr_full(1'b1, 5);
    repeat (2) tick();
    wr_full(1'b0, 5);
    repeat (10) tick();
    chk("R7 count held", int'(cur_count), 3);
    chk("R7 no irq", int'(irq), 0);
    wr_full(1'b1, 0);
    tick();
    chk("R8 set", int'(irq), 1);
    wr_full(1'b0, 0);
    repeat (5) tick();
    chk("R7 pending kept", int'(irq), 1);
    clr_pend();
    chk("R8 clear", int'(irq), 0);

    // Fire and clear together
    wr_full(1'b1, 0);
    tick();
    @(negedge clk); base_tick = 1'b1; pend_clr = 1'b1;
    @(negedge clk); base_tick = 1'b0; pend_clr = 1'b0;
    chk("R8 set wins", int'(irq), 1);
    chk("R9 evt high", int'(tick_evt), 1);
    @(negedge clk);
    chk("R9 evt one cycle", int'(tick_evt), 0);
    clr_pend();
    chk("R8 clear after", int'(irq), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule